// File: doc/BRIEF.md
# Eight-bit event timer with shared prescaler

This block is an 8-bit up-counter whose increments come either from a one-cycle instruction strobe (`cyc_en`) or from a chosen edge of an external count pin. A single power-of-two prescaler sits in front of the counter, or it can be handed to a separate watchdog. When it is handed over, the block sends the watchdog a prescaled tick and the counter counts every event with no division. Software writes a 7-bit control word and can write the count directly. When the count wraps, a sticky overflow flag is set. The block also samples an external interrupt pin and sets a sticky flag on the edge that the control word selects.

Both pins pass through a two-flop synchronizer before their edges are detected. A write to the count starts a small guard state machine. It has three states: `ST_RUN` (counting allowed), `ST_HOLD2` (two instruction strobes still to wait) and `ST_HOLD1` (one strobe still to wait). It has three transitions. LOAD goes from any state to `ST_HOLD2` on a count write. STEP2 goes from `ST_HOLD2` to `ST_HOLD1` on a strobe. RELEASE goes from `ST_HOLD1` to `ST_RUN` on a strobe. The counter and a prescaler that belongs to the timer do not advance outside `ST_RUN`.

Top module: `tmr_unit`

## Requirements
- R1: After reset the count, the control word, both flags and `wdog_tick` are all 0, and the guard state is `ST_RUN`.
- R2: With control bit 0 = 0 (instruction strobe as source) and bit 2 = 0 (prescaler to the timer), the count rises by one every 2^(rate+1) strobes, where rate is control bits 5:3. The ratio therefore runs from 1:2 to 1:256.
- R3: With bit 0 = 1, the counter counts edges of `tclk_pin`: rising edges when bit 1 = 0 and falling edges when bit 1 = 1. If the pin changes before clock edge k, the count changes at edge k+2.
- R4: With bit 2 = 1, the counter advances once per selected event with no division. `wdog_tick` pulses for one cycle, one cycle after every 2^rate-th strobe, so the ratio runs from 1:1 to 1:128.
- R5: With bit 2 = 0, `wdog_tick` equals `cyc_en` delayed by one cycle.
- R6: A count write loads `cnt_wdata` at the next edge and clears the prescaler. It moves the guard state machine to `ST_HOLD2`. No count increment happens until two more strobes have arrived after the write cycle.
- R7: A step from 0xFF to 0x00 sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed. A set in the same cycle as a clear wins.
- R8: Control bit 6 chooses which edge of the synchronized `int_pin` sets `ext_flag`: rising when 1, falling when 0. The flag sets two edges after the synchronizer and stays set until `ext_clr`. A set in the same cycle as a clear wins.
- R9: `tmr_ctl` reads back the written control bits 6:0. Every control write clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle strobe |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word write data |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_clr | input | 1 | Clears the external interrupt flag |
| tclk_pin | input | 1 | External count pin (asynchronous) |
| int_pin | input | 1 | External interrupt pin (asynchronous) |
| tmr_count | output | 8 | Current count |
| tmr_ctl | output | 7 | Control word readback |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external edge flag |
| wdog_tick | output | 1 | Tick to the watchdog |

## Verification
The counter is driven first by a sparse instruction strobe at two prescale ratios, which shows whether the division is 2^(rate+1) or off by one power. It is then driven by pin edges with the strobe held low, once for each edge polarity. This separates rising-edge counting from falling-edge counting and confirms the two-cycle synchronizer latency. Handing the prescaler to the watchdog at ratios 1:1 and 1:8 distinguishes the two ratio formulas and shows that the timer then counts with no division. A count write made near 0xFF, followed by strobes, exposes both the two-strobe guard and the wrap into the overflow flag. Repeated control writes placed halfway through a prescale period show whether the prescaler is cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned RATE_W = 3;

    // control word: bit0 source, bit1 source edge, bit2 prescaler owner,
    // bits 5:3 rate, bit6 interrupt-pin edge
    typedef struct packed {
        logic              int_rise;
        logic [RATE_W-1:0] rate;
        logic              pre_wdog;
        logic              src_fall;
        logic              src_ext;
    } tmr_ctl_t;

    localparam int unsigned CTL_W = $bits(tmr_ctl_t);

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLD2 = 2'd2
    } hold_st_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_q;
    logic            synced;
    logic            prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], pin};
    end

    assign synced = pipe_q[STAGES-1];
    assign prev   = pipe_q[STAGES];
    assign rise   = synced & ~prev;
    assign fall   = ~synced & prev;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic              to_wdog,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int unsigned CNT_W = 2 ** RATE_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] mask;
    logic [RATE_W:0]  shamt;

    always_comb begin
        shamt   = {1'b0, rate} + {{RATE_W{1'b0}}, ~to_wdog};
        span    = {{CNT_W{1'b0}}, 1'b1} << shamt;
        span_m1 = span - {{CNT_W{1'b0}}, 1'b1};
        mask    = span_m1[CNT_W-1:0];
    end

    assign tick = adv && ((cnt_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + 1'b1;
    end

    assert_pre_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    assert_pre_unity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (to_wdog && rate == '0 && adv) |-> tick);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int unsigned TMR_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cnt_wr,
    input  logic [TMR_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    input  logic             ext_clr,
    input  logic             tclk_pin,
    input  logic             int_pin,
    output logic [TMR_W-1:0] tmr_count,
    output logic [CTL_W-1:0] tmr_ctl,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             wdog_tick
);
    tmr_ctl_t   ctl_q;
    hold_st_t   state_q, state_d;
    logic [TMR_W-1:0] count_q;
    logic       ovf_q, ext_q, wd_q;
    logic       t_rise, t_fall, i_rise, i_fall;
    logic       raw_evt, int_evt, running;
    logic       pre_clr, pre_adv, pre_tick, cnt_step;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_tsync (
        .clk(clk), .rst_n(rst_n), .pin(tclk_pin), .rise(t_rise), .fall(t_fall));
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_isync (
        .clk(clk), .rst_n(rst_n), .pin(int_pin), .rise(i_rise), .fall(i_fall));

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctl_q <= '0;
        else if (ctl_wr)  ctl_q <= tmr_ctl_t'(ctl_wdata);
    end

    // guard state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // guard next state: LOAD, STEP2, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = ST_RUN;
            ST_HOLD2: if (cyc_en) state_d = ST_HOLD1;
            ST_HOLD1: if (cyc_en) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
        if (cnt_wr) state_d = ST_HOLD2;
    end

    // guard output
    always_comb begin
        running = 1'b0;
        unique case (state_q)
            ST_RUN:   running = !cnt_wr;
            ST_HOLD2,
            ST_HOLD1: running = 1'b0;
            default:  running = 1'b0;
        endcase
    end

    assign raw_evt = ctl_q.src_ext ? (ctl_q.src_fall ? t_fall : t_rise) : cyc_en;
    assign int_evt = ctl_q.int_rise ? i_rise : i_fall;
    assign pre_clr = cnt_wr || ctl_wr;
    assign pre_adv = !pre_clr && (ctl_q.pre_wdog ? cyc_en : (raw_evt && running));

    tmr_prescale #(.RATE_W(RATE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .adv(pre_adv),
        .to_wdog(ctl_q.pre_wdog), .rate(ctl_q.rate), .tick(pre_tick));

    assign cnt_step = running && (ctl_q.pre_wdog ? raw_evt : pre_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
            ext_q   <= 1'b0;
            wd_q    <= 1'b0;
        end else begin
            if (cnt_wr)        count_q <= cnt_wdata;
            else if (cnt_step) count_q <= count_q + 1'b1;

            if (cnt_step && count_q == '1) ovf_q <= 1'b1;
            else if (ovf_clr)              ovf_q <= 1'b0;

            if (int_evt)      ext_q <= 1'b1;
            else if (ext_clr) ext_q <= 1'b0;

            wd_q <= ctl_q.pre_wdog ? pre_tick : cyc_en;
        end
    end

    assign tmr_count = count_q;
    assign tmr_ctl   = ctl_q;
    assign ovf_flag  = ovf_q;
    assign ext_flag  = ext_q;
    assign wdog_tick = wd_q;

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (tmr_count == $past(cnt_wdata)));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !cnt_wr) |=> $stable(tmr_count));
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (tmr_count == $past(tmr_count) || tmr_count == $past(tmr_count) + 1'b1));
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && tmr_count == '1) |=> (ovf_flag && tmr_count == '0));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    assert_ext_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !ext_clr) |=> ext_flag);
    assert_wdtick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.pre_wdog |=> (wdog_tick == $past(cyc_en)));
endmodule

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_en = 0, ctl_wr = 0, cnt_wr = 0, ovf_clr = 0, ext_clr = 0;
    logic tclk_pin = 0, int_pin = 0;
    logic [6:0] ctl_wdata = '0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] tmr_count;
    logic [6:0] tmr_ctl;
    logic ovf_flag, ext_flag, wdog_tick;

    int checks = 0;
    int errors = 0;
    int wd_seen = 0;
    int cyc_total = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0, m_pre = 0, m_hold = 0, m_ctl = 0;
    bit m_ovf = 0, m_ext = 0, m_wd = 0;
    bit tq[$] = '{0, 0, 0};
    bit iq[$] = '{0, 0, 0};

    always #2.5 clk = ~clk;

    tmr_unit u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .ovf_clr(ovf_clr), .ext_clr(ext_clr),
        .tclk_pin(tclk_pin), .int_pin(int_pin),
        .tmr_count(tmr_count), .tmr_ctl(tmr_ctl),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .wdog_tick(wdog_tick));

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_hold = 0; m_ctl = 0;
            m_ovf = 0; m_ext = 0; m_wd = 0;
            tq = '{0, 0, 0}; iq = '{0, 0, 0};
        end else begin
            bit ext_src, fall_sel, wd_own, int_up, ev, iev, run, clr, adv, ptick, stp;
            int rate, ratio;
            ext_src  = m_ctl[0];
            fall_sel = m_ctl[1];
            wd_own   = m_ctl[2];
            rate     = (m_ctl >> 3) & 7;
            int_up   = m_ctl[6];
            ev  = ext_src ? (fall_sel ? (!tq[1] && tq[2]) : (tq[1] && !tq[2])) : cyc_en;
            iev = int_up ? (iq[1] && !iq[2]) : (!iq[1] && iq[2]);
            run = (m_hold == 0) && !cnt_wr;
            clr = cnt_wr || ctl_wr;
            ratio = wd_own ? (1 << rate) : (2 << rate);
            adv = !clr && (wd_own ? cyc_en : (ev && run));
            ptick = adv && ((m_pre % ratio) == ratio - 1);
            stp = run && (wd_own ? ev : ptick);
            m_wd = wd_own ? ptick : cyc_en;
            if (clr) m_pre = 0; else if (adv) m_pre = (m_pre + 1) % 256;
            if (cnt_wr) m_hold = 2; else if (m_hold > 0 && cyc_en) m_hold = m_hold - 1;
            if (stp && m_cnt == 255) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
            if (cnt_wr) m_cnt = cnt_wdata; else if (stp) m_cnt = (m_cnt + 1) % 256;
            if (iev) m_ext = 1; else if (ext_clr) m_ext = 0;
            if (ctl_wr) m_ctl = ctl_wdata;
            tq.push_front(tclk_pin); void'(tq.pop_back());
            iq.push_front(int_pin);  void'(iq.pop_back());
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(cur_req, tmr_count, m_cnt);
        chk("R7", ovf_flag, m_ovf);
        chk("R8", ext_flag, m_ext);
        chk(m_ctl[2] ? "R4" : "R5", wdog_tick, m_wd);
        chk("R9", tmr_ctl, m_ctl);
        if (wdog_tick) wd_seen++;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            cyc_en = (i % 4 == 3);
            tick();
        end
        cyc_en = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_ctl(int v);
        ctl_wr = 1; ctl_wdata = v[6:0]; tick(); ctl_wr = 0;
    endtask

    task automatic wr_cnt(int v);
        cnt_wr = 1; cnt_wdata = v[7:0]; tick(); cnt_wr = 0;
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            errors++;
            $display("FAIL watchdog (all): actual %0d cycles expected fewer", cyc_total);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        idle(3);
        @(negedge clk); rst_n = 1;
        tick();
        // R1 reset state
        chk("R1", tmr_count, 0); chk("R1", tmr_ctl, 0);
        chk("R1", ovf_flag, 0); chk("R1", ext_flag, 0); chk("R1", wdog_tick, 0);

        // R2 internal strobe, prescaler to timer
        cur_req = "R2";
        run(64);                 // 16 strobes at 1:2
        chk("R2", tmr_count, 8);
        wr_ctl(7'h10);           // rate 2 -> 1:8
        run(128);                // 32 strobes
        chk("R2", tmr_count, 12);

        // R6 count write and guard, R7 wrap
        cur_req = "R6";
        wr_ctl(7'h00);
        wr_cnt(8'hFD);
        chk("R6", tmr_count, 8'hFD);
        run(8);                  // two strobes absorbed by the guard
        chk("R6", tmr_count, 8'hFD);
        cur_req = "R7";
        run(24);                 // 6 strobes at 1:2 -> +3, wraps
        chk("R7", tmr_count, 0);
        chk("R7", ovf_flag, 1);
        idle(3);
        chk("R7", ovf_flag, 1);
        ovf_clr = 1; tick(); ovf_clr = 0;
        chk("R7", ovf_flag, 0);

        // R3 external pin edges, unprescaled
        cur_req = "R3";
        wr_ctl(7'h05);
        wr_cnt(0);
        run(8);
        for (int k = 0; k < 5; k++) begin
            tclk_pin = 1; idle(3); tclk_pin = 0; idle(3);
        end
        chk("R3", tmr_count, 5);
        tclk_pin = 1; tick(); tick();
        chk("R3", tmr_count, 5);
        tick();
        chk("R3", tmr_count, 6);
        tclk_pin = 0; idle(3);
        chk("R3", tmr_count, 6);
        wr_ctl(7'h07);           // falling edges
        for (int k = 0; k < 4; k++) begin
            tclk_pin = 1; idle(3); tclk_pin = 0; idle(3);
        end
        chk("R3", tmr_count, 10);

        // R4 prescaler to watchdog
        cur_req = "R4";
        wr_ctl(7'h1C);           // internal, watchdog owns, rate 3 -> 1:8
        base = wd_seen;
        run(128);                // 32 strobes
        chk("R4", wd_seen - base, 4);
        chk("R4", tmr_count, 42);
        wr_ctl(7'h04);           // rate 0 -> 1:1
        base = wd_seen;
        run(16);
        chk("R4", wd_seen - base, 4);

        // R5 prescaler to timer: tick follows the strobe
        cur_req = "R5";
        wr_ctl(7'h00);
        base = wd_seen;
        run(32);
        chk("R5", wd_seen - base, 8);
        chk("R5", tmr_count, 50);

        // R8 interrupt pin
        cur_req = "R8";
        int_pin = 1; idle(4);
        chk("R8", ext_flag, 0);
        int_pin = 0; tick(); tick();
        chk("R8", ext_flag, 0);
        tick();
        chk("R8", ext_flag, 1);
        ext_clr = 1; tick(); ext_clr = 0;
        chk("R8", ext_flag, 0);
        wr_ctl(7'h40);
        int_pin = 1; idle(4);
        chk("R8", ext_flag, 1);
        ext_clr = 1; tick(); ext_clr = 0;
        int_pin = 0; idle(4);
        chk("R8", ext_flag, 0);

        // R9 readback and prescaler clear on control write
        cur_req = "R9";
        wr_ctl(7'h2A);
        chk("R9", tmr_ctl, 7'h2A);
        wr_ctl(7'h7F);
        chk("R9", tmr_ctl, 7'h7F);
        wr_ctl(7'h00);
        run(4);                  // prescaler at half period
        base = tmr_count;
        wr_ctl(7'h00);           // clears it
        run(4);
        chk("R9", tmr_count, base);
        run(4);
        chk("R9", tmr_count, (base + 1) % 256);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule